// File: doc/BRIEF.md
# Complementary PWM Timer with Dead Time

This block is a 16-bit up-counting timer. A power-of-two prescaler sets its count rate. The counter starts at 1, advances on each prescaled tick and returns to 1 when it reaches a programmed reload value. The block raises a one-cycle pulse on every reload.

In the single-output modes the main output toggles on each reload. In the dual-output PWM mode the block drives a main output and a complementary output:

- A compare match drives one output inactive and the other active.
- A reload reverses the pair.
- A programmable dead time of 0 to 7 clock cycles keeps both outputs inactive before either one becomes active.

A polarity bit selects the idle and inactive level. While the timer runs, a change to this bit takes effect only at a period boundary.

The controlling logic sets the mode, polarity, prescale, dead time, reload and compare inputs and then raises the enable input. Lowering the enable input stops the timer. While it is low, the outputs rest at the levels set by the polarity bit.

Top module: `pwm_dt_timer`

## Requirements
- R1: The counter advances once every 2^`pres` clock cycles, where `pres` ranges from 0 (every cycle) to 7 (every 128 cycles).
- R2: The prescaler is cleared while `en` is low. The first tick comes in the (2^`pres`)-th cycle of enable. The first reload pulse therefore comes in cycle `reload_val`*2^`pres` - 1, counting the first enabled cycle as cycle 0.
- R3: The count starts at 1 and increments on each tick. On a tick where the count equals `reload_val`, `reload_pulse` is high for that cycle and the count returns to 1.
- R4: The mode codes are 4'b0000 one-shot, 4'b0001 continuous and 4'b0011 dual-output PWM. One-shot gives exactly one reload pulse and then holds until `en` falls. Continuous and PWM repeat indefinitely. Any other code holds the counter and gives no reload pulses.
- R5: While `en` is low, in every mode, `tmr_out` equals `pol` and `tmr_out_n` equals its inverse.
- R6: In the one-shot and continuous modes, `tmr_out` inverts in the cycle after each reload pulse. `tmr_out_n` is always its inverse. Changing `pol` while running has no effect in these modes.
- R7: In PWM mode the active level is the inverse of the polarity in force. In the cycle after a compare tick (count equals `cmp_val`), `tmr_out_n` goes to the polarity level at once, and `tmr_out` becomes active once the dead time has elapsed. In the cycle after a reload, `tmr_out` goes to the polarity level at once, and `tmr_out_n` becomes active once the dead time has elapsed.
- R8: With `dead` = d, both PWM outputs stay at the polarity level for exactly d cycles after each compare or reload event. A value of 0 inserts no gap.
- R9: In PWM mode while enabled, the two outputs are never active in the same cycle.
- R10: In PWM mode, the polarity in force is sampled when `en` rises and again at each reload. A change to `pol` while running appears from the cycle after the next reload pulse.
- R11: If a compare tick and a reload tick coincide, the reload wins and the compare is ignored. A reload that arrives during a dead interval restarts the interval.
- R12: During and right after reset with `en` low, `reload_pulse` is low and the outputs follow `pol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timer run enable |
| mode | input | 4 | Mode code (one-shot, continuous, dual PWM) |
| pol | input | 1 | Output polarity / idle level |
| pres | input | 3 | Prescale exponent, divide by 2^pres |
| dead | input | 3 | Dead time in clock cycles |
| reload_val | input | 16 | Count at which the period ends |
| cmp_val | input | 16 | PWM compare count |
| tmr_out | output | 1 | Main timer output |
| tmr_out_n | output | 1 | Complementary timer output |
| reload_pulse | output | 1 | One-cycle pulse on each reload tick |

## Verification
A compare event and a reload event can fall on the same tick. A reload can also land while a dead interval from the previous compare is still counting down. The bench provokes the first case by setting `cmp_val` equal to `reload_val`. It provokes the second by choosing a dead time longer than the gap between compare and reload. In both cases the cycle-by-cycle reference model has the reload override the compare. The bench judges each cycle against that model and also confirms that the main output never becomes active when the two counts coincide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_ONESHOT = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_CONT    = 4'b0001;
  localparam logic [MODE_W-1:0] MODE_PWM2    = 4'b0011;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] pre_q, pre_d, mask;

  always_comb begin
    mask  = ~({DIV_W{1'b1}} << sel);
    pre_d = en ? pre_q + DIV_W'(1) : '0;
    tick  = en & ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      reload_val,
  input  logic [W-1:0]      cmp_val,
  output logic              rl,
  output logic              mt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         done_q, done_d;
  logic         mode_ok, run;

  always_comb begin
    mode_ok = (mode == MODE_ONESHOT) || (mode == MODE_CONT) || (mode == MODE_PWM2);
    run     = en & mode_ok & ~done_q;
    rl      = run & tick & (cnt_q == reload_val);
    mt      = run & tick & (cnt_q == cmp_val);
    cnt_d   = cnt_q;
    done_d  = done_q;
    if (!en) begin
      cnt_d  = W'(1);
      done_d = 1'b0;
    end else if (run && tick) begin
      cnt_d = rl ? W'(1) : cnt_q + W'(1);
      if (rl && mode == MODE_ONESHOT) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= W'(1);
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R3
  reload_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rl |=> (cnt_q == W'(1)));

  // R4
  oneshot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rl && mode == MODE_ONESHOT) |=> !rl);
endmodule

// File: rtl/tmr_outstage.sv
module tmr_outstage #(
  parameter int DT_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            pwm_mode,
  input  logic            pol,
  input  logic [DT_W-1:0] dead,
  input  logic            rl,
  input  logic            mt,
  output logic            main_o,
  output logic            comp_o
);
  logic            ph_q, ph_d;
  logic [DT_W-1:0] dc_q, dc_d;
  logic            pa_q, pa_d;
  logic            s_q, s_d;
  logic            gap;

  always_comb begin
    ph_d = ph_q;
    dc_d = dc_q;
    pa_d = pa_q;
    s_d  = s_q;
    if (!en) begin
      ph_d = 1'b0;
      dc_d = '0;
      pa_d = pol;
      s_d  = pol;
    end else if (rl) begin
      ph_d = 1'b0;
      dc_d = dead;
      pa_d = pol;
      s_d  = ~s_q;
    end else if (mt) begin
      ph_d = 1'b1;
      dc_d = dead;
    end else if (dc_q != '0) begin
      dc_d = dc_q - DT_W'(1);
    end
  end

  always_comb begin
    gap = (dc_q != '0);
    if (!en) begin
      main_o = pol;
      comp_o = ~pol;
    end else if (pwm_mode) begin
      main_o = (ph_q && !gap) ? ~pa_q : pa_q;
      comp_o = (!ph_q && !gap) ? ~pa_q : pa_q;
    end else begin
      main_o = s_q;
      comp_o = ~s_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      dc_q <= '0;
      pa_q <= 1'b0;
      s_q  <= 1'b0;
    end else begin
      ph_q <= ph_d;
      dc_q <= dc_d;
      pa_q <= pa_d;
      s_q  <= s_d;
    end
  end

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwm_mode) |-> !(main_o == ~pa_q && comp_o == ~pa_q));

  // R8
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwm_mode && dc_q != '0) |-> (main_o == pa_q && comp_o == pa_q));

  // R10
  pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(rl)) |-> (pa_q == $past(pa_q)));
endmodule

// File: rtl/pwm_dt_timer.sv
module pwm_dt_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRES_W = 3,
  parameter int DT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [MODE_W-1:0] mode,
  input  logic              pol,
  input  logic [PRES_W-1:0] pres,
  input  logic [DT_W-1:0]   dead,
  input  logic [CNT_W-1:0]  reload_val,
  input  logic [CNT_W-1:0]  cmp_val,
  output logic              tmr_out,
  output logic              tmr_out_n,
  output logic              reload_pulse
);
  logic tick, rl, mt, pwm_mode;

  assign pwm_mode     = (mode == MODE_PWM2);
  assign reload_pulse = rl;

  tmr_prescale #(.SEL_W(PRES_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .en(en), .sel(pres), .tick(tick)
  );

  tmr_count #(.W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .mode(mode),
    .reload_val(reload_val), .cmp_val(cmp_val), .rl(rl), .mt(mt)
  );

  tmr_outstage #(.DT_W(DT_W)) i_out (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm_mode(pwm_mode), .pol(pol),
    .dead(dead), .rl(rl), .mt(mt), .main_o(tmr_out), .comp_o(tmr_out_n)
  );

  // R12
  idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !reload_pulse);
endmodule

// File: tb/test_pwm_dt_timer.sv
module test_pwm_dt_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [3:0] mode = 4'b0001;
  logic pol = 1'b1;
  logic [2:0] pres = 3'd0;
  logic [2:0] dead = 3'd0;
  logic [15:0] reload_val = 16'd5;
  logic [15:0] cmp_val = 16'd2;
  logic tmr_out, tmr_out_n, reload_pulse;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pwm_dt_timer i_pwm_dt_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .pol(pol), .pres(pres),
    .dead(dead), .reload_val(reload_val), .cmp_val(cmp_val),
    .tmr_out(tmr_out), .tmr_out_n(tmr_out_n), .reload_pulse(reload_pulse)
  );

  // behavioural reference state
  int m_pre, m_cnt, m_dc;
  bit m_done, m_ph, m_pa, m_s;

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 1; m_dc = 0;
      m_done = 0; m_ph = 0; m_pa = 0; m_s = 0;
    end else begin
      int mask;
      bit tk, runv, rlv, mtv, e_main, e_comp;
      mask = (1 << pres) - 1;
      tk   = en && ((m_pre & mask) == mask);
      runv = en && (mode == 4'b0000 || mode == 4'b0001 || mode == 4'b0011) && !m_done;
      rlv  = runv && tk && (m_cnt == int'(reload_val));
      mtv  = runv && tk && (m_cnt == int'(cmp_val));
      if (!en) begin
        e_main = pol; e_comp = !pol;
      end else if (mode == 4'b0011) begin
        e_main = (m_ph == 1 && m_dc == 0) ? !m_pa : m_pa;
        e_comp = (m_ph == 0 && m_dc == 0) ? !m_pa : m_pa;
      end else begin
        e_main = m_s; e_comp = !m_s;
      end
      check("R3 reload_pulse", int'(reload_pulse), int'(rlv));
      if (!en) check("R5 outputs", {tmr_out, tmr_out_n}, {e_main, e_comp});
      else if (mode == 4'b0011) check("R7 outputs", {tmr_out, tmr_out_n}, {e_main, e_comp});
      else check("R6 outputs", {tmr_out, tmr_out_n}, {e_main, e_comp});
      if (en && mode == 4'b0011)
        check("R9 overlap", int'(tmr_out == !m_pa && tmr_out_n == !m_pa), 0);
      // next state
      if (!en) begin
        m_pre = 0; m_cnt = 1; m_done = 0; m_ph = 0; m_dc = 0; m_pa = pol; m_s = pol;
      end else begin
        m_pre = (m_pre + 1) % 128;
        if (runv && tk) begin
          m_cnt = rlv ? 1 : (m_cnt + 1) % 65536;
          if (rlv && mode == 4'b0000) m_done = 1;
        end
        if (rlv) begin
          m_ph = 0; m_dc = dead; m_pa = pol; m_s = !m_s;
        end else if (mtv) begin
          m_ph = 1; m_dc = dead;
        end else if (m_dc > 0) m_dc--;
      end
    end
  end

  task automatic setup(bit e, logic [3:0] md, bit p, int pr, int dt, int rv, int cv);
    @(posedge clk); #1;
    en = e; mode = md; pol = p; pres = 3'(pr); dead = 3'(dt);
    reload_val = 16'(rv); cmp_val = 16'(cv);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset main", int'(tmr_out), 1);
    check("R12 reset comp", int'(tmr_out_n), 0);
    check("R12 reset pulse", int'(reload_pulse), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check("R12 after reset", {tmr_out, reload_pulse}, 2'b10);

    // continuous, several patterns
    setup(1, 4'b0001, 1, 0, 0, 5, 2); idle(30);
    setup(0, 4'b0001, 0, 0, 0, 5, 2); idle(2);
    @(negedge clk); check("R5 disabled pol0", {tmr_out, tmr_out_n}, 2'b01);
    setup(1, 4'b0001, 0, 1, 0, 3, 2); idle(10);
    pol = 1'b1; idle(20);   // R6: no effect in single mode
    setup(0, 4'b0001, 1, 0, 0, 5, 2); idle(2);

    // R1 / R2: first pulse timing and period with pres=3 reload=3
    setup(1, 4'b0001, 1, 3, 0, 3, 2);
    begin
      int first, second;
      first = -1; second = -1;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk);
        if (reload_pulse) begin
          if (first < 0) first = c;
          else if (second < 0) second = c;
        end
      end
      check("R2 first pulse cycle", first, 23);
      check("R1 pulse period", second - first, 24);
    end
    setup(0, 4'b0001, 1, 0, 0, 5, 2); idle(2);

    // R1 large prescale
    setup(1, 4'b0001, 1, 7, 0, 2, 1); idle(600);
    setup(0, 4'b0001, 1, 0, 0, 5, 2); idle(2);

    // R4 one-shot
    setup(1, 4'b0000, 1, 0, 0, 4, 2);
    begin
      int n; n = 0;
      for (int c = 0; c < 40; c++) begin @(negedge clk); if (reload_pulse) n++; end
      check("R4 one-shot pulses", n, 1);
    end
    setup(0, 4'b0000, 1, 0, 0, 4, 2); idle(2);
    setup(1, 4'b0000, 0, 2, 0, 3, 2); idle(40);
    setup(0, 4'b0000, 1, 0, 0, 4, 2); idle(2);

    // R4 unsupported code holds counter
    setup(1, 4'b0010, 1, 0, 0, 3, 2);
    begin
      int n; n = 0;
      for (int c = 0; c < 30; c++) begin @(negedge clk); if (reload_pulse) n++; end
      check("R4 other code pulses", n, 0);
    end
    setup(0, 4'b0010, 1, 0, 0, 3, 2); idle(2);

    // R8 dead time 3, pol 1
    setup(1, 4'b0011, 1, 0, 3, 10, 4);
    begin
      int n; n = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk); if (tmr_out && tmr_out_n) n++;
      end
      check("R8 dead cycles", n, 21);
    end
    setup(0, 4'b0011, 1, 0, 0, 10, 4); idle(2);

    // R7 / R8 zero dead time, pol 0, prescale 2
    setup(1, 4'b0011, 0, 1, 0, 6, 3); idle(50);
    setup(0, 4'b0011, 0, 0, 0, 6, 3); idle(2);

    // R11 reload during dead interval
    setup(1, 4'b0011, 1, 0, 7, 6, 3); idle(40);
    setup(0, 4'b0011, 1, 0, 0, 6, 3); idle(2);

    // R11 compare coincides with reload
    setup(1, 4'b0011, 1, 0, 0, 5, 5);
    begin
      int n; n = 0;
      for (int c = 0; c < 30; c++) begin @(negedge clk); if (!tmr_out) n++; end
      check("R11 coincident compare ignored", n, 0);
    end
    setup(0, 4'b0011, 1, 0, 0, 5, 5); idle(2);

    // R10 polarity change while running
    setup(1, 4'b0011, 1, 0, 0, 8, 20); idle(2);
    #1 pol = 1'b0;
    @(negedge clk); check("R10 no immediate change", int'(tmr_out), 1);
    begin
      int guard; guard = 0;
      while (!reload_pulse && guard < 50) begin @(negedge clk); guard++; end
      @(negedge clk);
      check("R10 applied after reload", {tmr_out, tmr_out_n}, 2'b01);
    end
    idle(20);
    setup(1, 4'b0011, 1, 2, 2, 4, 2); idle(60);
    setup(0, 4'b0011, 1, 0, 0, 4, 2); idle(3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule